// File: doc/BRIEF.md
# Core Sleep and Wake Controller

This block decides when a small processor core may halt its clock and when it must resume. The instruction pipeline hands it two kinds of sleep request. One is a wait for an event. The other is a wait for an interrupt. The rest of the chip reports exceptions being taken, interrupts going pending, debug-entry requests and external events. The controller raises a core-stopped level that the clock gating cells use. It emits a one-cycle wake strobe when the core is released. Only the core stops; the surrounding system keeps its clocks.

The two sleep entries treat history in different ways. The event wait works through a sticky one-bit local event register. That register records events and taken exceptions that arrive while the core runs, so a later event wait consumes the flag and completes without stopping. The interrupt wait always stops the core. It reacts only to things that happen after it is issued: an interrupt line that was already high does not release it. Before the core stops, the controller waits until a bus-busy input reads idle, so that transfers already in flight can complete.

Top module: `core_sleep_ctrl`

## Requirements
- R1: After reset, core_stopped and wake_pulse are 0 and the local event flag is 0, so a first event wait puts the core to sleep.
- R2: An event wait issued while the flag is 1 clears the flag and completes without the core stopping. A second event wait right after it does stop the core.
- R3: An event wait issued while the flag is 0 stops the core. The core wakes on ext_evt, on exc_taken, or on dbg_req when dbg_en is 1. A dbg_req with dbg_en at 0 does not wake it.
- R4: While asleep on an event wait, a rising edge of irq_pend wakes the core only if sev_on_pend is 1.
- R5: While the core is not in an event wait, the flag is set by ext_evt, by sev_pulse, by exc_taken, or by a rising edge of irq_pend when sev_on_pend is 1.
- R6: An interrupt wait always stops the core, even when the flag is 1 and irq_pend is already high. It leaves the flag unchanged.
- R7: While asleep on an interrupt wait, the core wakes on exc_taken, on a rising edge of irq_pend with irq_preempt at 1, or on dbg_req whatever the value of dbg_en. The inputs ext_evt, dbg_en and sev_on_pend do not wake it.
- R8: core_stopped rises only on the clock edge after a cycle in which bus_busy is 0. While bus_busy stays 1, the core keeps running.
- R9: wake_pulse lasts one cycle and core_stopped falls on the next edge. A wake condition seen while waiting for the bus is remembered, so the core then sleeps for exactly one cycle.
- R10: When wfe_req and wfi_req arrive in the same cycle, the event wait is the one carried out.
- R11: Sleep requests that arrive while a wait is already pending or the core is asleep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfe_req | input | 1 | Event-wait request from the pipeline |
| wfi_req | input | 1 | Interrupt-wait request from the pipeline |
| sev_pulse | input | 1 | The core's own send-event pulse |
| ext_evt | input | 1 | Event from another core or peripheral |
| exc_taken | input | 1 | An unmasked exception is taken |
| irq_pend | input | 1 | Level: some interrupt is pending |
| irq_preempt | input | 1 | The pending interrupt would preempt |
| dbg_req | input | 1 | Debug-entry request |
| dbg_en | input | 1 | Debug is enabled |
| sev_on_pend | input | 1 | A new pending interrupt counts as an event |
| bus_busy | input | 1 | Core bus transfers are still outstanding |
| core_stopped | output | 1 | Core clock may be gated |
| wake_pulse | output | 1 | One-cycle strobe releasing the core |

## Verification
The hardest case to reach from the ports is a wake that arrives during the bus-drain window. It takes effect only as a one-cycle sleep. The stimulus holds bus_busy high across a sleep request, injects an exception, and then releases the bus. Near that, the bench sweeps every wake source against both wait kinds and every setting of dbg_en, sev_on_pend and irq_preempt. The flag's contents are never read directly. The bench infers them from whether a following event wait stops the core.

// File: rtl/csc_pkg.sv
package csc_pkg;

  typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_SLEEP} slp_state_t;
  typedef enum logic {WM_EVENT, WM_IRQ} wait_kind_t;

  // Sources that post to the local event flag while the core is not in an event wait
  function automatic logic flag_sets(input logic ext, input logic sev, input logic exc,
                                     input logic irq_rise, input logic sop);
    return ext | sev | exc | (irq_rise & sop);
  endfunction

  // Release conditions for an event wait
  function automatic logic evwait_wakes(input logic ext, input logic exc, input logic dbg,
                                        input logic den, input logic irq_rise, input logic sop);
    return ext | exc | (dbg & den) | (irq_rise & sop);
  endfunction

  // Release conditions for an interrupt wait (debug regardless of enable)
  function automatic logic irqwait_wakes(input logic exc, input logic irq_rise,
                                         input logic pre, input logic dbg);
    return exc | (irq_rise & pre) | dbg;
  endfunction

endpackage

// File: rtl/csc_rise_det.sv
module csc_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/csc_event_flag.sv
module csc_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_src,
  input  logic hold_off,
  input  logic consume,
  output logic flag
);
  logic set_eff;
  assign set_eff = set_src & ~hold_off;

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~consume) | set_eff;
  end

  // R2: consuming with no new arrival empties the flag
  a_r2_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !set_src) |=> !flag);
  // R5: an accepted arrival is remembered
  a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_src && !hold_off) |=> flag);
  // R3: while an event wait is pending, the flag cannot rise
  a_r3_no_post_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_off && !flag) |=> !flag);
endmodule

// File: rtl/csc_sleep_fsm.sv
module csc_sleep_fsm
  import csc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfe_req,
  input  logic       wfi_req,
  input  logic       flag,
  input  logic       bus_busy,
  input  logic       wake_ev,
  input  logic       wake_irq,
  output logic       consume,
  output logic       ev_wait,
  output logic       core_stopped,
  output logic       wake_pulse
);
  slp_state_t state, state_n;
  wait_kind_t kind, kind_n;
  logic       wake_seen, wake_seen_n;
  logic       wake_now;

  assign wake_now     = (kind == WM_EVENT) ? wake_ev : wake_irq;
  assign ev_wait      = (state != ST_RUN) && (kind == WM_EVENT);
  assign core_stopped = (state == ST_SLEEP);
  assign wake_pulse   = (state == ST_SLEEP) && (wake_now || wake_seen);
  assign consume      = (state == ST_RUN) && wfe_req && flag;

  always_comb begin
    state_n     = state;
    kind_n      = kind;
    wake_seen_n = wake_seen;
    case (state)
      ST_RUN: begin
        wake_seen_n = 1'b0;
        if (wfe_req) begin
          if (!flag) begin
            state_n = ST_DRAIN;
            kind_n  = WM_EVENT;
          end
        end else if (wfi_req) begin
          state_n = ST_DRAIN;
          kind_n  = WM_IRQ;
        end
      end
      ST_DRAIN: begin
        wake_seen_n = wake_seen | wake_now;
        if (!bus_busy) state_n = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_pulse) begin
          state_n     = ST_RUN;
          wake_seen_n = 1'b0;
        end
      end
      default: state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      kind      <= WM_EVENT;
      wake_seen <= 1'b0;
    end else begin
      state     <= state_n;
      kind      <= kind_n;
      wake_seen <= wake_seen_n;
    end
  end

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  a_r9_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !core_stopped);
  a_r9_pulse_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> core_stopped);
  a_r8_bus_idle_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stopped) |-> $past(!bus_busy));
  a_r11_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stopped && !wake_pulse) |=> core_stopped);
  a_r2_flag_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (state == ST_RUN));
endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
  import csc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfe_req,
  input  logic wfi_req,
  input  logic sev_pulse,
  input  logic ext_evt,
  input  logic exc_taken,
  input  logic irq_pend,
  input  logic irq_preempt,
  input  logic dbg_req,
  input  logic dbg_en,
  input  logic sev_on_pend,
  input  logic bus_busy,
  output logic core_stopped,
  output logic wake_pulse
);
  logic irq_rise;
  logic flag;
  logic consume;
  logic ev_wait;
  logic post_evt;
  logic wake_ev;
  logic wake_irq;

  csc_rise_det u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (irq_pend),
    .rise (irq_rise)
  );

  assign post_evt = flag_sets(ext_evt, sev_pulse, exc_taken, irq_rise, sev_on_pend);
  assign wake_ev  = evwait_wakes(ext_evt, exc_taken, dbg_req, dbg_en, irq_rise, sev_on_pend);
  assign wake_irq = irqwait_wakes(exc_taken, irq_rise, irq_preempt, dbg_req);

  csc_event_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_src (post_evt),
    .hold_off(ev_wait),
    .consume (consume),
    .flag    (flag)
  );

  csc_sleep_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wfe_req     (wfe_req),
    .wfi_req     (wfi_req),
    .flag        (flag),
    .bus_busy    (bus_busy),
    .wake_ev     (wake_ev),
    .wake_irq    (wake_irq),
    .consume     (consume),
    .ev_wait     (ev_wait),
    .core_stopped(core_stopped),
    .wake_pulse  (wake_pulse)
  );

  // R6: an interrupt wait leaves the flag alone
  a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ev_wait && !wfe_req) |=> flag);
endmodule

// File: tb/tb_core_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_core_sleep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfe_req = 0, wfi_req = 0, sev_pulse = 0, ext_evt = 0, exc_taken = 0;
  logic irq_pend = 0, irq_preempt = 0, dbg_req = 0, dbg_en = 0, sev_on_pend = 0, bus_busy = 0;
  logic core_stopped, wake_pulse;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  core_sleep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wfe_req(wfe_req), .wfi_req(wfi_req),
    .sev_pulse(sev_pulse), .ext_evt(ext_evt), .exc_taken(exc_taken),
    .irq_pend(irq_pend), .irq_preempt(irq_preempt), .dbg_req(dbg_req),
    .dbg_en(dbg_en), .sev_on_pend(sev_on_pend), .bus_busy(bus_busy),
    .core_stopped(core_stopped), .wake_pulse(wake_pulse)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    {wfe_req, wfi_req, sev_pulse, ext_evt, exc_taken, irq_pend} = '0;
    {irq_preempt, dbg_req, dbg_en, sev_on_pend, bus_busy} = '0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  // issue a request for one cycle, then one drain cycle with bus idle
  task automatic req_and_settle(input bit use_wfe);
    if (use_wfe) wfe_req = 1; else wfi_req = 1;
    tick();
    wfe_req = 0; wfi_req = 0;
    tick();
  endtask

  task automatic wake_by_exc(input string tag);
    exc_taken = 1; #1;
    chk(wake_pulse, 1'b1, tag);
    tick();
    exc_taken = 0;
    chk(core_stopped, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset values, empty flag
    chk(core_stopped, 1'b0, "R1 stopped");
    chk(wake_pulse, 1'b0, "R1 wake");
    req_and_settle(1);
    chk(core_stopped, 1'b1, "R1 first wfe sleeps");
    wake_by_exc("R1 release");

    // R5 and R2: each poster fills the flag, wfe consumes it, next wfe sleeps
    for (int s = 0; s < 5; s++) begin
      logic exp_set;
      do_reset();
      sev_on_pend = (s != 4);
      case (s)
        0: ext_evt = 1;
        1: sev_pulse = 1;
        2: exc_taken = 1;
        default: irq_pend = 1;
      endcase
      tick();
      {ext_evt, sev_pulse, exc_taken} = '0;
      exp_set = (s != 4);
      req_and_settle(1);
      chk(core_stopped, !exp_set, "R5 flag posted");
      if (exp_set) begin
        tick();
        chk(core_stopped, 1'b0, "R2 no stop");
        req_and_settle(1);
        chk(core_stopped, 1'b1, "R2 flag cleared");
      end
      wake_by_exc("R2 release");
      irq_pend = 0;
    end

    // R3 R4 R7 R6: sweep wake source x wait kind x config
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 8; c++) begin
          logic den, sop, pre, exp_w;
          string tg;
          den = c[0]; sop = c[1]; pre = c[2];
          do_reset();
          dbg_en = den; sev_on_pend = sop; irq_preempt = pre;
          req_and_settle(m == 0);
          chk(core_stopped, 1'b1, (m == 0) ? "R3 enter" : "R6 enter");
          if (m == 0) begin
            exp_w = (s == 0) ? 1'b1 : (s == 1) ? 1'b1 : (s == 2) ? den : sop;
            tg = (s == 3) ? "R4 event wait irq" : "R3 event wait source";
          end else begin
            exp_w = (s == 0) ? 1'b0 : (s == 1) ? 1'b1 : (s == 2) ? 1'b1 : pre;
            tg = "R7 irq wait source";
          end
          case (s)
            0: ext_evt = 1;
            1: exc_taken = 1;
            2: dbg_req = 1;
            default: irq_pend = 1;
          endcase
          #1;
          chk(wake_pulse, exp_w, tg);
          tick();
          {ext_evt, exc_taken, dbg_req} = '0;
          chk(core_stopped, !exp_w, tg);
          chk(wake_pulse, 1'b0, "R9 single pulse");
          irq_pend = 0;
        end

    // R6: flag set and irq already pending; wfi still stops, flag survives
    do_reset();
    irq_preempt = 1; sev_on_pend = 1;
    sev_pulse = 1; tick(); sev_pulse = 0;
    irq_pend = 1; tick();
    req_and_settle(0);
    chk(core_stopped, 1'b1, "R6 wfi stops despite history");
    repeat (3) tick();
    chk(core_stopped, 1'b1, "R6 old irq no wake");
    dbg_req = 1; #1;
    chk(wake_pulse, 1'b1, "R7 debug wakes");
    tick(); dbg_req = 0;
    req_and_settle(1);
    chk(core_stopped, 1'b0, "R6 flag kept");
    irq_pend = 0;

    // R8: bus busy delays stop
    do_reset();
    bus_busy = 1;
    req_and_settle(1);
    repeat (3) tick();
    chk(core_stopped, 1'b0, "R8 busy holds run");
    bus_busy = 0; tick();
    chk(core_stopped, 1'b1, "R8 stop after idle");
    wake_by_exc("R8 release");

    // R9: wake during drain gives a one-cycle sleep
    do_reset();
    bus_busy = 1;
    req_and_settle(0);
    exc_taken = 1; tick(); exc_taken = 0;
    chk(core_stopped, 1'b0, "R9 still draining");
    bus_busy = 0; tick();
    chk(core_stopped, 1'b1, "R9 short sleep");
    chk(wake_pulse, 1'b1, "R9 remembered wake");
    tick();
    chk(core_stopped, 1'b0, "R9 released");

    // R10: both requests with flag set -> event wait wins, no stop
    do_reset();
    ext_evt = 1; tick(); ext_evt = 0;
    wfe_req = 1; wfi_req = 1; tick(); wfe_req = 0; wfi_req = 0;
    tick();
    chk(core_stopped, 1'b0, "R10 event wait chosen");

    // R11: requests while asleep have no effect
    do_reset();
    req_and_settle(0);
    wfe_req = 1; #1;
    chk(wake_pulse, 1'b0, "R11 no wake");
    tick(); wfe_req = 0; tick();
    chk(core_stopped, 1'b1, "R11 still asleep");
    wake_by_exc("R11 release");
    tick();
    chk(core_stopped, 1'b0, "R11 stays running");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule